// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is a small general-purpose I/O port that sits on an 8-bit register bus. It holds an output data latch and a direction register, and it provides a read-only view of the synchronized pad levels. From these it produces, for every pin, an output-enable, an output value and a pull-up enable that an external pad model uses.

A pin whose direction bit is set is driven from its latch bit. A pin whose direction bit is clear is an input, and its latch bit then turns on the pull-up. A global pull-up-disable input, which comes from a control register elsewhere, overrides every pull-up.

Pins 0 to 4 are full push-pull pins. The highest pin is restricted to open-drain: it can pull its pad low or let it go, and it never drives high. Pad levels pass through a synchronizer before software can read them. Reset releases every pad at once, without waiting for a clock edge.

Top module: `gpio_port`

## Requirements
- R1: For a push-pull pin (pins 0 to 4), `pad_oe[i]` equals the stored direction bit: direction 1 makes the pin an output and direction 0 makes it an input.
- R2: A push-pull pin with direction 1 drives `pad_out[i]` equal to its latch bit and has `pad_pu[i]` = 0. Whenever `pad_oe[i]` is 0, `pad_out[i]` is 0.
- R3: An input pin (direction 0) whose latch bit is 1 has `pad_pu[i]` = 1 while `pud_all` is 0, and `pad_pu[i]` = 0 while `pud_all` is 1. Toggling `pud_all` takes effect without a bus write.
- R4: An input pin whose latch bit is 0 is high impedance with no pull-up: `pad_oe`, `pad_out` and `pad_pu` are all 0 for that pin.
- R5: Pin 5 is open-drain. `pad_oe[5]` is 1 only when its direction bit is 1 and its latch bit is 0. `pad_out[5]` and `pad_pu[5]` are always 0.
- R6: A write with `bus_we` = 1 to address 0x18 (latch) or 0x17 (direction) stores `bus_wdata[5:0]` at the next rising clock edge. A read with `bus_re` = 1 returns the stored bits in `bus_rdata[5:0]`.
- R7: A read of address 0x16 returns the pad levels sampled through a two-flop synchronizer, so a pad change is first visible two rising edges later. The pin view holds no storage, and a write to 0x16 changes no latch or direction bit.
- R8: Bits 7 and 6 read as 0 at every address, and writes to those bits are ignored.
- R9: Asserting `rst_n` low clears the latch and direction registers to 0 and forces every `pad_oe` and `pad_pu` bit to 0 at once, before any clock edge.
- R10: `bus_rdata` is 0 while `bus_re` is 0 and for any unmapped address. A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Combinational read data |
| pud_all | input | 1 | Global pull-up disable |
| pad_in | input | 6 | Raw pad levels, asynchronous to `clk` |
| pad_oe | output | 6 | Per-pin output enable |
| pad_out | output | 6 | Per-pin output value |
| pad_pu | output | 6 | Per-pin pull-up enable |

## Verification
The bench builds the port with its default parameters: six pins, an 8-bit data bus, the open-drain mask selecting only pin 5, and a two-stage synchronizer. With these values the bench can reach the asymmetry between the push-pull pins and the open-drain pin, the two unimplemented upper data bits, and the exact two-edge latency of the pin view. A table of direction, latch, pull-up-disable and pad patterns is applied in turn. After it come directed tests for:
- asynchronous reset between clock edges,
- writes to the pin view and to unmapped addresses,
- reads with the strobe low,
- toggling `pud_all` without a bus write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Which register a bus address selects
    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_PINS  = 2'd3
    } reg_sel_e;

    // Control bundle for one pad
    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
    } pin_ctl_t;

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  gpio_pkg::reg_sel_e   wr_sel,
    input  logic                 wr_en,
    input  logic [W-1:0]         wr_data,
    output logic [W-1:0]         latch_o,
    output logic [W-1:0]         dir_o
);
    import gpio_pkg::*;

    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] dir;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_LATCH: st_d.latch = wr_data;
                SEL_DIR:   st_d.dir   = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_o = st_q.latch;
    assign dir_o   = st_q.dir;

    // R6: a latch write lands on the next edge
    a_r6_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_LATCH) |=> (latch_o == $past(wr_data)));

    // R6: a direction write lands on the next edge
    a_r6_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DIR) |=> (dir_o == $past(wr_data)));

    // R7, R10: no write strobe to latch/dir leaves both registers unchanged
    a_r7_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_sel == SEL_LATCH || wr_sel == SEL_DIR))
        |=> ($stable(latch_o) && $stable(dir_o)));

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  async_i,
    output logic [W-1:0]  sync_o
);
    localparam int SEEN_W = $clog2(STAGES + 1);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

    // Checker: edges seen since reset, saturating
    logic [SEEN_W-1:0] seen_d, seen_q;

    always_comb begin
        seen_d = seen_q;
        if (seen_q != SEEN_W'(STAGES)) seen_d = seen_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end

    // R7: first stage captures the pad level of the previous cycle
    a_r7_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q != '0) |-> (chain_q[0] == $past(async_i)));

    // R7: output only moves once a value has crossed the full chain
    a_r7_chain_settled: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == SEEN_W'(STAGES)) |-> (sync_o == $past(chain_q[STAGES-2])));

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
    parameter int           W       = 6,
    parameter logic [W-1:0] OD_MASK = '0
) (
    input  logic          rst_n,
    input  logic [W-1:0]  dir_i,
    input  logic [W-1:0]  latch_i,
    input  logic          pud_i,
    output logic [W-1:0]  oe_o,
    output logic [W-1:0]  out_o,
    output logic [W-1:0]  pu_o
);
    import gpio_pkg::*;

    pin_ctl_t ctl [W];

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (OD_MASK[i]) begin : g_od
            // Open-drain: pull low only, never a pull-up
            always_comb begin
                ctl[i].oe  = rst_n & dir_i[i] & ~latch_i[i];
                ctl[i].out = 1'b0;
                ctl[i].pu  = 1'b0;
            end
        end else begin : g_pp
            // Push-pull: latch drives when output, enables pull-up when input
            always_comb begin
                ctl[i].oe  = rst_n & dir_i[i];
                ctl[i].out = rst_n & dir_i[i] & latch_i[i];
                ctl[i].pu  = rst_n & ~dir_i[i] & latch_i[i] & ~pud_i;
            end
        end
        assign oe_o[i]  = ctl[i].oe;
        assign out_o[i] = ctl[i].out;
        assign pu_o[i]  = ctl[i].pu;
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int             W           = 6,
    parameter int             ADDR_W      = 6,
    parameter int             DATA_W      = 8,
    parameter int             SYNC_STAGES = 2,
    parameter logic [W-1:0]   OD_MASK     = 6'b100000,
    parameter logic [ADDR_W-1:0] LATCH_ADDR = 6'h18,
    parameter logic [ADDR_W-1:0] DIR_ADDR   = 6'h17,
    parameter logic [ADDR_W-1:0] PINS_ADDR  = 6'h16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_we,
    input  logic               bus_re,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               pud_all,
    input  logic [W-1:0]       pad_in,
    output logic [W-1:0]       pad_oe,
    output logic [W-1:0]       pad_out,
    output logic [W-1:0]       pad_pu
);
    import gpio_pkg::*;

    reg_sel_e     sel;
    logic [W-1:0] latch_q, dir_q, pins_sync;
    logic         unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:W];

    always_comb begin
        if      (bus_addr == LATCH_ADDR) sel = SEL_LATCH;
        else if (bus_addr == DIR_ADDR)   sel = SEL_DIR;
        else if (bus_addr == PINS_ADDR)  sel = SEL_PINS;
        else                             sel = SEL_NONE;
    end

    gpio_regs #(.W(W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (sel),
        .wr_en   (bus_we),
        .wr_data (bus_wdata[W-1:0]),
        .latch_o (latch_q),
        .dir_o   (dir_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (pins_sync)
    );

    gpio_pad_ctl #(.W(W), .OD_MASK(OD_MASK)) i_pad (
        .rst_n   (rst_n),
        .dir_i   (dir_q),
        .latch_i (latch_q),
        .pud_i   (pud_all),
        .oe_o    (pad_oe),
        .out_o   (pad_out),
        .pu_o    (pad_pu)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            unique case (sel)
                SEL_LATCH: bus_rdata[W-1:0] = latch_q;
                SEL_DIR:   bus_rdata[W-1:0] = dir_q;
                SEL_PINS:  bus_rdata[W-1:0] = pins_sync;
                default:   ;
            endcase
        end
    end

    // R9: released pads during reset, independent of the clock
    always_comb begin
        if (!rst_n) begin
            a_r9_reset_tristate: assert ((pad_oe == '0) && (pad_pu == '0));
        end
    end

    // R8: upper data bits never carry data
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:W] == '0);

    // R10: no strobe means a quiet read bus
    a_r10_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> (bus_rdata == '0));

    // R2, R3: a pad is never both driven and pulled up
    a_r3_pu_vs_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pu) == '0);

    // R2: output value only meaningful while enabled
    a_r2_out_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    for (genvar i = 0; i < W; i++) begin : g_chk
        if (OD_MASK[i]) begin : g_od_chk
            // R5: open-drain pin never drives high, never pulls up
            a_r5_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
                !pad_out[i] && !pad_pu[i]);
        end else begin : g_pp_chk
            // R1: push-pull enable follows a direction write one edge later
            a_r1_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && sel == SEL_DIR) |=> (pad_oe[i] == $past(bus_wdata[i])));
        end
    end

endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       pud_all = 1'b0;
    logic [5:0] pad_in = '0;
    logic [5:0] pad_oe, pad_out, pad_pu;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pud_all(pud_all), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    localparam logic [5:0] A_LATCH = 6'h18;
    localparam logic [5:0] A_DIR   = 6'h17;
    localparam logic [5:0] A_PINS  = 6'h16;

    // Vector fields: dir[18:13] latch[12:7] pud[6] pad[5:0]
    localparam int NV = 8;
    localparam logic [18:0] VEC [NV] = '{
        {6'h00, 6'h00, 1'b0, 6'h15},
        {6'h3F, 6'h3F, 1'b0, 6'h2A},
        {6'h3F, 6'h00, 1'b0, 6'h3F},
        {6'h00, 6'h3F, 1'b0, 6'h00},
        {6'h00, 6'h3F, 1'b1, 6'h33},
        {6'h2A, 6'h15, 1'b0, 6'h0C},
        {6'h15, 6'h2A, 1'b1, 6'h21},
        {6'h20, 6'h1F, 1'b0, 6'h1E}
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        bus_re = 1'b0;
    endtask

    // Expected pad controls from the requirements
    function automatic logic [17:0] model(input logic [5:0] dir,
                                          input logic [5:0] lat, input logic pud);
        logic [5:0] oe, out, pu;
        for (int i = 0; i < 5; i++) begin
            oe[i]  = dir[i];
            out[i] = dir[i] & lat[i];
            pu[i]  = ~dir[i] & lat[i] & ~pud;
        end
        oe[5] = dir[5] & ~lat[5];
        out[5] = 1'b0;
        pu[5] = 1'b0;
        return {oe, out, pu};
    endfunction

    task automatic chk_pads(input string req, input logic [5:0] dir,
                            input logic [5:0] lat, input logic pud);
        logic [17:0] e;
        e = model(dir, lat, pud);
        chk(req, "pad_oe",  {2'b0, pad_oe},  {2'b0, e[17:12]});
        chk(req, "pad_out", {2'b0, pad_out}, {2'b0, e[11:6]});
        chk(req, "pad_pu",  {2'b0, pad_pu},  {2'b0, e[5:0]});
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        // R9: reset state
        #12;
        chk("R9", "oe in reset", {2'b0, pad_oe}, 8'h00);
        chk("R9", "pu in reset", {2'b0, pad_pu}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        bus_read(A_LATCH, rd); chk("R9", "latch reset", rd, 8'h00);
        bus_read(A_DIR, rd);   chk("R9", "dir reset", rd, 8'h00);

        // Table walk: R1..R7
        for (int v = 0; v < NV; v++) begin
            logic [5:0] d, l, p;
            logic pu;
            d = VEC[v][18:13]; l = VEC[v][12:7]; pu = VEC[v][6]; p = VEC[v][5:0];
            bus_write(A_DIR, {2'b11, d});
            bus_write(A_LATCH, {2'b11, l});
            pud_all = pu; pad_in = p;
            @(negedge clk); @(negedge clk);
            chk_pads("R1 R2 R3 R4 R5", d, l, pu);
            bus_read(A_LATCH, rd); chk("R6 R8", "latch read", rd, {2'b0, l});
            bus_read(A_DIR, rd);   chk("R6 R8", "dir read", rd, {2'b0, d});
            bus_read(A_PINS, rd);  chk("R7", "pin view", rd, {2'b0, p});
        end

        // R3: pud_all alone changes pull-ups
        bus_write(A_DIR, 8'h00);
        bus_write(A_LATCH, 8'h3F);
        pud_all = 1'b0; #1;
        chk("R3", "pu enabled", {2'b0, pad_pu}, 8'h1F);
        pud_all = 1'b1; #1;
        chk("R3", "pu disabled", {2'b0, pad_pu}, 8'h00);
        pud_all = 1'b0;

        // R5: pin 5 open-drain combinations
        bus_write(A_DIR, 8'h20); bus_write(A_LATCH, 8'h00);
        chk("R5", "od pull low oe", {7'b0, pad_oe[5]}, 8'h01);
        chk("R5", "od out", {7'b0, pad_out[5]}, 8'h00);
        bus_write(A_DIR, 8'h00);
        chk("R5", "od input no pu", {7'b0, pad_pu[5]}, 8'h00);

        // R7: synchronizer latency
        @(negedge clk); pad_in = 6'h00;
        @(negedge clk); @(negedge clk);
        pad_in = 6'h3F;
        @(negedge clk);
        bus_read(A_PINS, rd); chk("R7", "pin view after 1 edge", rd, 8'h00);
        @(negedge clk);
        bus_read(A_PINS, rd); chk("R7", "pin view after 2 edges", rd, 8'h3F);

        // R7: write to pin view is ignored
        bus_write(A_DIR, 8'h05); bus_write(A_LATCH, 8'h0A);
        bus_write(A_PINS, 8'hFF);
        bus_read(A_LATCH, rd); chk("R7", "latch after pins write", rd, 8'h0A);
        bus_read(A_DIR, rd);   chk("R7", "dir after pins write", rd, 8'h05);
        chk_pads("R7", 6'h05, 6'h0A, 1'b0);

        // R10: unmapped write and read, read strobe low
        bus_write(6'h19, 8'hFF);
        bus_write(6'h00, 8'hFF);
        bus_read(A_LATCH, rd); chk("R10", "latch after unmapped write", rd, 8'h0A);
        bus_read(A_DIR, rd);   chk("R10", "dir after unmapped write", rd, 8'h05);
        bus_read(6'h19, rd);   chk("R10", "unmapped read", rd, 8'h00);
        bus_addr = A_LATCH; bus_re = 1'b0; #1;
        chk("R10", "strobe low read", bus_rdata, 8'h00);

        // R8: upper bits
        bus_write(A_LATCH, 8'hC0);
        bus_read(A_LATCH, rd); chk("R8", "upper bits ignored", rd, 8'h00);

        // R9: asynchronous reset between edges
        bus_write(A_DIR, 8'h3F); bus_write(A_LATCH, 8'h1F);
        @(negedge clk); #2;
        rst_n = 1'b0; #1;
        chk("R9", "async oe", {2'b0, pad_oe}, 8'h00);
        chk("R9", "async pu", {2'b0, pad_pu}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        bus_read(A_DIR, rd); chk("R9", "dir cleared", rd, 8'h00);
        bus_read(A_LATCH, rd); chk("R9", "latch cleared", rd, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule